// File: doc/BRIEF.md
# Windowed Keyed Watchdog Counter

This block is a run-mode watchdog. A counter advances on each qualified tick of the watchdog clock, which arrives as a one-cycle enable from whichever clock source the surrounding logic has picked. The timeout period is a power of two set by a 5-bit exponent. When the count reaches the end of the period without being serviced, the block raises a one-cycle non-maskable interrupt request. The counter then wraps to zero and keeps running, so another request follows each period until software services the watchdog or turns it off.

Software services the watchdog by writing one exact 16-bit key. In window mode a service is accepted only in the final part of the period. The size of that part is chosen by a 2-bit code. A correct key that arrives earlier is treated as a fault: it raises the interrupt request and restarts the count. Configuration inputs can force the watchdog on and force window mode on, and software cannot clear either forced state. A debug clear and a clock-switch event both restart the count without raising a request.

Top module: `wdog_top`

## Requirements
- R1: With exponent N on `postDiv`, the first timeout request comes on the 2^N-th tick after the counter was last cleared. The request appears in the cycle after the edge that takes that tick.
- R2: After a timeout the counter restarts from zero and keeps counting. An unserviced watchdog therefore raises one request every 2^N ticks.
- R3: A service is recognised only when `keyWr` is high and `keyData` equals 16'h5743. A write of any other value leaves the count unchanged and raises no request.
- R4: In window mode the allowed window is the last part of the period, chosen by `winCode`: 2'b11 is 1/4, 2'b10 is 3/8, 2'b01 is 1/2 and 2'b00 is 3/4. Each fraction is rounded down to whole ticks. A service is early when the count is below the period minus the window.
- R5: An early service raises the request in the next cycle and restarts the count from zero.
- R6: A service in window mode inside the window, or any service outside window mode, restarts the count from zero and raises no request.
- R7: While the watchdog is disabled (`swEnable` and `cfgForceEn` both low), the count is held at zero and no request is raised. `enActive` reads 0 in this state.
- R8: When `cfgForceEn` is high, `enActive` reads 1 and the watchdog counts even with `swEnable` low. When `cfgForceWin` is high, `winActive` reads 1 and window mode applies even with `swWinEn` low.
- R9: `dbgClear` and `clkSwitch` each restart the count from zero and raise no request. They take priority over a key write and over a tick in the same cycle.
- R10: `nmiReq` is a pulse one cycle wide per event. It is low in any cycle that follows a cycle with no event.
- R11: After reset, `nmiReq` is low and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle tick from the selected watchdog clock source |
| keyWr | input | 1 | Strobe for a write to the service key |
| keyData | input | 16 | Value written to the service key |
| swEnable | input | 1 | Software enable |
| swWinEn | input | 1 | Software window-mode enable |
| winCode | input | 2 | Window size code |
| postDiv | input | 5 | Period exponent N; period is 2^N ticks |
| cfgForceEn | input | 1 | Configuration forces the watchdog on |
| cfgForceWin | input | 1 | Configuration forces window mode on |
| dbgClear | input | 1 | Debug command that clears the count |
| clkSwitch | input | 1 | Clock-switch event that clears the count |
| nmiReq | output | 1 | One-cycle non-maskable interrupt request |
| enActive | output | 1 | Effective enable as software reads it |
| winActive | output | 1 | Effective window mode as software reads it |

## Verification
The bench keeps the default 5-bit exponent and the 32-bit counter that follows from it. It drives small exponents so that every period stays within a few dozen ticks. With N=4 the period is 16 ticks, and each of the four window codes then falls on a distinct whole-tick boundary (12, 10, 8 and 4), so early and in-window service can be tested on both sides of each boundary. N=2 and N=0 show repeated wrap-around timeouts, and at N=0 a timeout comes on every tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int POST_W = 5;
  localparam int KEY_W  = 16;
  localparam logic [KEY_W-1:0] SERVICE_KEY = 16'h5743;

  typedef enum logic [1:0] {
    WIN_3Q  = 2'b00,
    WIN_1H  = 2'b01,
    WIN_3E  = 2'b10,
    WIN_1Q  = 2'b11
  } winSel_e;

  typedef struct packed {
    logic clr;
    logic inc;
  } cntStrb_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int PW    = POST_W,
  localparam int CW   = 2 ** PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cntStrb_t      strb,
  input  logic [PW-1:0] postDiv,
  input  logic [1:0]    winCode,
  output logic          atTop,
  output logic          beforeWin
);
  logic [CW-1:0] cnt;
  logic [CW:0]   period;
  logic [CW:0]   lastCnt;
  logic [CW:0]   winSize;
  logic [CW:0]   boundary;

  always_comb begin
    period  = (CW+1)'(1) << postDiv;
    lastCnt = period - (CW+1)'(1);
    unique case (winSel_e'(winCode))
      WIN_1Q:  winSize = period >> 2;
      WIN_3E:  winSize = (period >> 2) + (period >> 3);
      WIN_1H:  winSize = period >> 1;
      default: winSize = (period >> 1) + (period >> 2);
    endcase
    boundary  = period - winSize;
    atTop     = {1'b0, cnt} >= lastCnt;
    beforeWin = {1'b0, cnt} < boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (strb.clr) cnt <= '0;
    else if (strb.inc) cnt <= cnt + 1'b1;
  end

  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clr |=> cnt == '0);
  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.inc && !strb.clr) |=> cnt == $past(cnt) + 1'b1);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.inc && !strb.clr) |=> $stable(cnt));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             keyWr,
  input  logic [KEY_W-1:0] keyData,
  input  logic             swEnable,
  input  logic             swWinEn,
  input  logic             cfgForceEn,
  input  logic             cfgForceWin,
  input  logic             dbgClear,
  input  logic             clkSwitch,
  input  logic             atTop,
  input  logic             beforeWin,
  output cntStrb_t         strb,
  output logic             nmiReq,
  output logic             enActive,
  output logic             winActive
);
  logic keyHit;
  logic fault;

  assign enActive  = cfgForceEn | swEnable;
  assign winActive = cfgForceWin | swWinEn;
  assign keyHit    = keyWr && (keyData == SERVICE_KEY);

  always_comb begin
    strb  = '0;
    fault = 1'b0;
    if (!enActive) begin
      strb.clr = 1'b1;
    end else if (dbgClear || clkSwitch) begin
      strb.clr = 1'b1;
    end else if (keyHit) begin
      strb.clr = 1'b1;
      fault    = winActive && beforeWin;
    end else if (tickEn) begin
      if (atTop) begin
        strb.clr = 1'b1;
        fault    = 1'b1;
      end else begin
        strb.inc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmiReq <= 1'b0;
    else        nmiReq <= fault;
  end

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enActive |=> !nmiReq);
  p_dbg_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbgClear || clkSwitch) |=> !nmiReq);
  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (keyWr && keyData != SERVICE_KEY && !tickEn) |=> !nmiReq);
  p_early_nmi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enActive && keyHit && winActive && beforeWin && !dbgClear && !clkSwitch) |=> nmiReq);
  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && !keyWr) |=> !nmiReq);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              keyWr,
  input  logic [KEY_W-1:0]  keyData,
  input  logic              swEnable,
  input  logic              swWinEn,
  input  logic [1:0]        winCode,
  input  logic [POST_W-1:0] postDiv,
  input  logic              cfgForceEn,
  input  logic              cfgForceWin,
  input  logic              dbgClear,
  input  logic              clkSwitch,
  output logic              nmiReq,
  output logic              enActive,
  output logic              winActive
);
  cntStrb_t strb;
  logic     atTop;
  logic     beforeWin;

  wdog_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .keyWr(keyWr), .keyData(keyData),
    .swEnable(swEnable), .swWinEn(swWinEn), .cfgForceEn(cfgForceEn),
    .cfgForceWin(cfgForceWin), .dbgClear(dbgClear), .clkSwitch(clkSwitch),
    .atTop(atTop), .beforeWin(beforeWin), .strb(strb), .nmiReq(nmiReq),
    .enActive(enActive), .winActive(winActive)
  );

  wdog_datapath #(.PW(POST_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .postDiv(postDiv),
    .winCode(winCode), .atTop(atTop), .beforeWin(beforeWin)
  );
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickEn = 0, keyWr = 0, swEnable = 0, swWinEn = 0;
  logic cfgForceEn = 0, cfgForceWin = 0, dbgClear = 0, clkSwitch = 0;
  logic [15:0] keyData = '0;
  logic [1:0]  winCode = '0;
  logic [4:0]  postDiv = '0;
  logic nmiReq, enActive, winActive;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  wdog_top dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .keyWr(keyWr), .keyData(keyData),
    .swEnable(swEnable), .swWinEn(swWinEn), .winCode(winCode), .postDiv(postDiv),
    .cfgForceEn(cfgForceEn), .cfgForceWin(cfgForceWin), .dbgClear(dbgClear),
    .clkSwitch(clkSwitch), .nmiReq(nmiReq), .enActive(enActive), .winActive(winActive)
  );

  typedef struct packed {
    logic [4:0]  n;
    logic        win;
    logic [1:0]  code;
    logic [7:0]  pre;
    logic [15:0] key;
    logic        expKey;
    logic [7:0]  post;
    logic [7:0]  expCnt;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{5'd4, 1'b0, 2'b00, 8'd5,  16'h5743, 1'b0, 8'd15, 8'd0},  // R6 R1
    '{5'd4, 1'b0, 2'b00, 8'd5,  16'h5742, 1'b0, 8'd15, 8'd1},  // R3
    '{5'd4, 1'b1, 2'b11, 8'd11, 16'h5743, 1'b1, 8'd15, 8'd0},  // R4 R5
    '{5'd4, 1'b1, 2'b11, 8'd12, 16'h5743, 1'b0, 8'd15, 8'd0},  // R4 R6
    '{5'd4, 1'b1, 2'b10, 8'd9,  16'h5743, 1'b1, 8'd15, 8'd0},  // R4 R5
    '{5'd4, 1'b1, 2'b10, 8'd10, 16'h5743, 1'b0, 8'd15, 8'd0},  // R4
    '{5'd4, 1'b1, 2'b01, 8'd7,  16'h5743, 1'b1, 8'd15, 8'd0},  // R4
    '{5'd4, 1'b1, 2'b01, 8'd8,  16'h5743, 1'b0, 8'd15, 8'd0},  // R4
    '{5'd4, 1'b1, 2'b00, 8'd3,  16'h5743, 1'b1, 8'd15, 8'd0},  // R4
    '{5'd4, 1'b1, 2'b00, 8'd4,  16'h5743, 1'b0, 8'd15, 8'd0},  // R4
    '{5'd4, 1'b1, 2'b11, 8'd3,  16'h1234, 1'b0, 8'd13, 8'd1},  // R3
    '{5'd4, 1'b0, 2'b11, 8'd15, 16'h5743, 1'b0, 8'd16, 8'd1},  // R6 R1
    '{5'd2, 1'b0, 2'b00, 8'd0,  16'h5743, 1'b0, 8'd12, 8'd3},  // R2
    '{5'd0, 1'b0, 2'b00, 8'd0,  16'h5743, 1'b0, 8'd5,  8'd5},  // R2
    '{5'd3, 1'b0, 2'b00, 8'd2,  16'hA8BC, 1'b0, 8'd6,  8'd1},  // R3
    '{5'd5, 1'b0, 2'b00, 8'd20, 16'h5743, 1'b0, 8'd31, 8'd0}   // R1
  };

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic tick(output logic got);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    got = nmiReq;
  endtask

  task automatic ticks(input int n, output int cnt);
    logic g;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      tick(g);
      if (g) cnt++;
    end
  endtask

  task automatic writeKey(input logic [15:0] k, output logic got);
    keyWr = 1'b1;
    keyData = k;
    @(negedge clk);
    keyWr = 1'b0;
    got = nmiReq;
  endtask

  task automatic pulseDbg();
    dbgClear = 1'b1;
    @(negedge clk);
    dbgClear = 1'b0;
  endtask

  initial begin
    int c;
    logic g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 nmi after reset", nmiReq, 0);
    check("R7 enActive after reset", enActive, 0);
    check("R8 winActive after reset", winActive, 0);

    postDiv = 5'd2;
    ticks(20, c);
    check("R7 disabled no nmi", c, 0);

    swEnable = 1'b1;
    @(negedge clk);
    check("R7 enActive set", enActive, 1);

    for (int v = 0; v < NV; v++) begin
      postDiv = VECS[v].n;
      swWinEn = VECS[v].win;
      winCode = VECS[v].code;
      pulseDbg();
      ticks(int'(VECS[v].pre), c);
      check($sformatf("R1 vec%0d no early timeout", v), c, 0);
      writeKey(VECS[v].key, g);
      check($sformatf("R4/R5 vec%0d key nmi", v), g, VECS[v].expKey);
      ticks(int'(VECS[v].post), c);
      check($sformatf("R2/R6 vec%0d post nmi count", v), c, int'(VECS[v].expCnt));
    end
    swWinEn = 1'b0;

    // R10: the cycle after a timeout pulse has nmiReq low
    postDiv = 5'd1;
    pulseDbg();
    ticks(1, c);
    tick(g);
    check("R10 timeout pulse", g, 1);
    @(negedge clk);
    check("R10 pulse one cycle", nmiReq, 0);

    // R9 clock switch restarts the count
    postDiv = 5'd2;
    pulseDbg();
    ticks(3, c);
    clkSwitch = 1'b1; @(negedge clk); clkSwitch = 1'b0;
    ticks(3, c);
    check("R9 clkSwitch clears", c, 0);
    tick(g);
    check("R9 timeout after clkSwitch", g, 1);

    // R9 debug clear wins over a timeout tick in the same cycle
    pulseDbg();
    ticks(3, c);
    dbgClear = 1'b1; tickEn = 1'b1;
    @(negedge clk);
    dbgClear = 1'b0; tickEn = 1'b0;
    check("R9 dbgClear beats tick", nmiReq, 0);
    ticks(3, c);
    check("R9 count restarted", c, 0);

    // R8 forced enable
    swEnable = 1'b0; cfgForceEn = 1'b1;
    @(negedge clk);
    check("R8 enActive forced", enActive, 1);
    ticks(4, c);
    check("R8 forced enable counts", c, 1);

    // R8 forced window: key at count 1 with code 11, N=4 is early
    cfgForceWin = 1'b1; swWinEn = 1'b0; postDiv = 5'd4; winCode = 2'b11;
    pulseDbg();
    check("R8 winActive forced", winActive, 1);
    ticks(1, c);
    writeKey(16'h5743, g);
    check("R8 forced window early nmi", g, 1);

    // R7 disable again
    cfgForceEn = 1'b0; cfgForceWin = 1'b0;
    ticks(40, c);
    check("R7 disabled again no nmi", c, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule